// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block is one core's private interval timer. A free-running prescaler divides the input clock by a programmable ratio and emits one tick per period. Each tick steps an interrupt down-counter, and when that counter runs out the block raises an interrupt flag. The block runs in one of two modes. In one-shot mode the counter stops at zero and stays there. In interval mode it reloads from its buffer and keeps firing until software stops it.

Software reaches the block through a simple write strobe and a combinational read port, inside a 256-byte window placed by a base-address parameter. Register offsets inside the window:

| Offset | Register |
|---|---|
| 0x00 | Prescaler buffer |
| 0x08 | Interrupt-count buffer |
| 0x20 | Control |
| 0x30 | Interrupt flag |
| 0x34 | Interrupt enable |
| 0x40 | Write-applied status |

Every buffered write takes effect on the clock edge that accepts it. A matching write-applied status bit then tells software that the write has landed. The interrupt flag and the write-applied bits are both cleared by writing ones to them.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the control, interrupt flag, interrupt enable, write-applied status and interrupt counter all read 0, and `irq_o` is low.
- R2: A write to offset 0x08 always stores bits [ICNT_W-1:0] in the count buffer. The live counter is loaded only when bit 31 of the written data is 1. A read of 0x08 returns the live counter.
- R3: With control bit 0 (prescaler run) and bit 1 (counter run) both set, the counter steps once every (prescaler buffer + 1) clocks. A count of N sets the flag N*(P+1) clocks after the edge that wrote the control register, where P is the prescaler buffer.
- R4: With control bit 2 clear (one-shot), the counter rests at 0 after it expires, and no further interrupt occurs.
- R5: With control bit 2 set (interval), the counter reloads from its buffer on expiry, and the flag sets again every N*(P+1) clocks.
- R6: Writing 1 to bit 0 at offset 0x30 clears the flag. `irq_o` is the flag gated by bit 0 of the enable register at 0x34. The flag still sets while the enable is 0.
- R7: Offset 0x40 sets bit 0 after a prescaler-buffer write, bit 1 after a count-buffer write and bit 3 after a control write. Writing 1 to a bit clears it.
- R8: Clearing the run bits halts the counter, and it holds its value.
- R9: A loaded count of 0 never raises the flag.
- R10: Only writes whose address falls in the 256-byte window at BASE_ADDR have any effect. Reads outside the window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Byte address for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Tick interrupt (flag AND enable) |

## Verification
The bench builds the block with BASE_ADDR set to 0x400, which places it in the second core's window. Writes aimed at the neighbouring window at 0x300 can then be shown to leave the block untouched. Prescaler ratios of 1, 2 and 3 and counts of 0, 1, 3, 4 and 100 keep the exact expiry cycles short enough to count one by one. These values cover one-shot, interval reload, halting mid-count and the zero-count case.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
    // Register offsets inside the 256-byte window
    localparam logic [7:0] OFF_TICK = 8'h00;
    localparam logic [7:0] OFF_ICNT = 8'h08;
    localparam logic [7:0] OFF_CTRL = 8'h20;
    localparam logic [7:0] OFF_STAT = 8'h30;
    localparam logic [7:0] OFF_IEN  = 8'h34;
    localparam logic [7:0] OFF_WST  = 8'h40;

    // Control bits
    localparam int CTRL_TMR = 0;
    localparam int CTRL_INT = 1;
    localparam int CTRL_IVL = 2;

    // Write-applied status bits
    localparam int WST_TICK = 0;
    localparam int WST_ICNT = 1;
    localparam int WST_CTRL = 3;

    // Load-request bit in a count-buffer write
    localparam int UPD_BIT = 31;
endpackage

// File: rtl/ctt_prescale.sv
module ctt_prescale #(
    parameter int TCNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [TCNT_W-1:0] load_val_i,
    output logic              tick_o,
    output logic [TCNT_W-1:0] rld_o
);
    typedef struct packed {
        logic [TCNT_W-1:0] rld;
        logic [TCNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && (st_q.cnt == '0);
        if (load_i) begin
            st_d.rld = load_val_i;
            st_d.cnt = load_val_i;
        end else if (tick_o) begin
            st_d.cnt = st_q.rld;
        end else if (run_i) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rld_o = st_q.rld;

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !load_i) |=> (st_q.cnt == $past(st_q.rld))); // R3
endmodule

// File: rtl/ctt_icount.sv
module ctt_icount #(
    parameter int ICNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              ivl_i,
    input  logic              wr_i,
    input  logic              upd_i,
    input  logic [ICNT_W-1:0] val_i,
    output logic [ICNT_W-1:0] cnt_o,
    output logic              expire_o
);
    typedef struct packed {
        logic [ICNT_W-1:0] rld;
        logic [ICNT_W-1:0] cnt;
    } ic_st_t;

    ic_st_t st_d, st_q;
    logic   force_ld;
    logic   step;

    always_comb begin
        st_d     = st_q;
        force_ld = wr_i && upd_i;
        step     = run_i && tick_i && (st_q.cnt != '0) && !force_ld;
        expire_o = step && (st_q.cnt == ICNT_W'(1));
        if (wr_i) st_d.rld = val_i;
        if (force_ld) begin
            st_d.cnt = val_i;
        end else if (step) begin
            if (expire_o) st_d.cnt = ivl_i ? st_q.rld : '0;
            else          st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !ivl_i) |=> (st_q.cnt == '0)); // R4
    AST_IVL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && ivl_i) |=> (st_q.cnt == $past(st_q.rld))); // R5
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !(wr_i && upd_i)) |=> $stable(st_q.cnt)); // R8
    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !expire_o); // R9
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
    parameter int              ADDR_W    = 12,
    parameter logic [11:0]     BASE_ADDR = 12'h300,
    parameter int              TCNT_W    = 32,
    parameter int              ICNT_W    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    import ctt_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_FULL = ADDR_W'(BASE_ADDR);
    localparam int                HI_W      = ADDR_W - 8;

    typedef struct packed {
        logic [2:0] ctrl;
        logic       ien;
        logic       flag;
        logic [3:0] wst;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              in_win;
    logic [7:0]        off;
    logic              wr_tick, wr_icnt, wr_ctrl, wr_stat, wr_ien, wr_wst;
    logic              tick;
    logic              expire;
    logic [TCNT_W-1:0] tick_rld;
    logic [ICNT_W-1:0] icnt;
    logic [3:0]        wst_set;

    assign in_win  = (bus_addr[ADDR_W-1:8] == BASE_FULL[ADDR_W-1:8]);
    assign off     = bus_addr[7:0];
    assign wr_tick = bus_wr && in_win && (off == OFF_TICK);
    assign wr_icnt = bus_wr && in_win && (off == OFF_ICNT);
    assign wr_ctrl = bus_wr && in_win && (off == OFF_CTRL);
    assign wr_stat = bus_wr && in_win && (off == OFF_STAT);
    assign wr_ien  = bus_wr && in_win && (off == OFF_IEN);
    assign wr_wst  = bus_wr && in_win && (off == OFF_WST);

    ctt_prescale #(.TCNT_W(TCNT_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q.ctrl[CTRL_TMR]),
        .load_i    (wr_tick),
        .load_val_i(bus_wdata[TCNT_W-1:0]),
        .tick_o    (tick),
        .rld_o     (tick_rld)
    );

    ctt_icount #(.ICNT_W(ICNT_W)) u_icnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (st_q.ctrl[CTRL_INT]),
        .tick_i  (tick),
        .ivl_i   (st_q.ctrl[CTRL_IVL]),
        .wr_i    (wr_icnt),
        .upd_i   (bus_wdata[UPD_BIT]),
        .val_i   (bus_wdata[ICNT_W-1:0]),
        .cnt_o   (icnt),
        .expire_o(expire)
    );

    always_comb begin
        st_d    = st_q;
        wst_set = '0;
        wst_set[WST_TICK] = wr_tick;
        wst_set[WST_ICNT] = wr_icnt;
        wst_set[WST_CTRL] = wr_ctrl;
        if (wr_ctrl) st_d.ctrl = bus_wdata[2:0];
        if (wr_ien)  st_d.ien  = bus_wdata[0];
        st_d.flag = (st_q.flag && !(wr_stat && bus_wdata[0])) || expire;
        st_d.wst  = (st_q.wst & ~(wr_wst ? bus_wdata[3:0] : 4'h0)) | wst_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            case (off)
                OFF_TICK: bus_rdata = 32'(tick_rld);
                OFF_ICNT: bus_rdata = 32'(icnt);
                OFF_CTRL: bus_rdata = 32'(st_q.ctrl);
                OFF_STAT: bus_rdata = 32'(st_q.flag);
                OFF_IEN:  bus_rdata = 32'(st_q.ien);
                OFF_WST:  bus_rdata = 32'(st_q.wst);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = st_q.flag && st_q.ien;

    AST_FLAG_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> ($past(icnt) == ICNT_W'(1))); // R3
    AST_W1C_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[0] && !expire) |=> !irq_o); // R6
    AST_WST_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> st_q.wst[WST_CTRL]); // R7
    AST_NO_HI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win) |-> (bus_rdata == 32'h0)); // R10

    initial begin
        AST_BASE_ALIGN: assert (HI_W > 0 && BASE_ADDR[7:0] == 8'h00); // R10
    end
endmodule

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb_top;
    localparam int          AW   = 12;
    localparam logic [11:0] BASE = 12'h400;
    localparam logic [11:0] A_TICK = BASE + 12'h00;
    localparam logic [11:0] A_ICNT = BASE + 12'h08;
    localparam logic [11:0] A_CTRL = BASE + 12'h20;
    localparam logic [11:0] A_STAT = BASE + 12'h30;
    localparam logic [11:0] A_IEN  = BASE + 12'h34;
    localparam logic [11:0] A_WST  = BASE + 12'h40;
    localparam logic [31:0] UPD    = 32'h8000_0000;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;

    int vectors = 0;
    int miscompares = 0;

    core_tick_timer #(.ADDR_W(AW), .BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bw(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk);
        #1 bus_wr = 0;
    endtask

    task automatic br(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_irq(input int max, output int at);
        at = -1;
        for (int c = 1; c <= max && at < 0; c++) begin
            @(posedge clk); @(negedge clk);
            if (irq_o) at = c;
        end
    endtask

    task automatic quiesce();
        bw(A_CTRL, 0); bw(A_IEN, 0); bw(A_STAT, 1); bw(A_WST, 32'hF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", irq_o, 0);
        br(A_CTRL, v); check("R1 ctrl", v, 0);
        br(A_STAT, v); check("R1 flag", v, 0);
        br(A_WST, v);  check("R1 wst", v, 0);
        br(A_ICNT, v); check("R1 icnt", v, 0);
        br(A_IEN, v);  check("R1 ien", v, 0);
    endtask

    task automatic t_wstat();
        logic [31:0] v;
        quiesce();
        br(A_WST, v); check("R7 cleared", v, 0);
        bw(A_TICK, 5);  br(A_WST, v); check("R7 tick bit", v, 1);
        bw(A_ICNT, 5);  br(A_WST, v); check("R7 icnt bit", v, 3);
        bw(A_CTRL, 0);  br(A_WST, v); check("R7 ctrl bit", v, 11);
        bw(A_WST, 2);   br(A_WST, v); check("R7 w1c one", v, 9);
        bw(A_WST, 9);   br(A_WST, v); check("R7 w1c rest", v, 0);
    endtask

    task automatic t_update();
        logic [31:0] v;
        quiesce();
        bw(A_ICNT, UPD | 5); br(A_ICNT, v); check("R2 load", v, 5);
        bw(A_ICNT, 9);       br(A_ICNT, v); check("R2 no load", v, 5);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        int at;
        int seen = 0;
        quiesce();
        bw(A_TICK, 2); bw(A_ICNT, UPD | 3); bw(A_IEN, 1); bw(A_CTRL, 3);
        wait_irq(60, at);
        check("R3 oneshot expiry cycle", at, 9);
        bw(A_STAT, 1);
        for (int c = 0; c < 30; c++) begin
            @(posedge clk); @(negedge clk);
            if (irq_o) seen++;
        end
        check("R4 no refire", seen, 0);
        br(A_ICNT, v); check("R4 rests at zero", v, 0);
    endtask

    task automatic t_interval();
        int hits[3];
        int n = 0;
        quiesce();
        bw(A_TICK, 1); bw(A_ICNT, UPD | 4); bw(A_IEN, 1); bw(A_CTRL, 7);
        bus_addr = A_STAT; bus_wdata = 1;
        for (int c = 1; c <= 40; c++) begin
            @(posedge clk); @(negedge clk);
            if (irq_o) begin
                if (n < 3) hits[n] = c;
                n++;
                bus_wr = 1;
            end else begin
                bus_wr = 0;
            end
        end
        bus_wr = 0;
        check("R5 first", hits[0], 8);
        check("R5 second", hits[1], 16);
        check("R5 third", hits[2], 24);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        quiesce();
        bw(A_TICK, 0); bw(A_ICNT, UPD | 1); bw(A_CTRL, 3);
        waitc(5);
        br(A_STAT, v); check("R6 flag while masked", v, 1);
        check("R6 irq masked", irq_o, 0);
        bw(A_IEN, 1);  check("R6 irq unmasked", irq_o, 1);
        bw(A_STAT, 1); check("R6 w1c", irq_o, 0);
    endtask

    task automatic t_halt();
        logic [31:0] a, b;
        quiesce();
        bw(A_TICK, 0); bw(A_ICNT, UPD | 100); bw(A_CTRL, 7);
        waitc(10);
        bw(A_CTRL, 4);
        br(A_ICNT, a); check("R8 halted value", a, 88);
        waitc(20);
        br(A_ICNT, b); check("R8 holds", b, a);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        quiesce();
        bw(A_TICK, 0); bw(A_ICNT, UPD | 0); bw(A_IEN, 1); bw(A_CTRL, 7);
        waitc(50);
        br(A_STAT, v); check("R9 zero count flag", v, 0);
        check("R9 zero count irq", irq_o, 0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        quiesce();
        bw(A_ICNT, UPD | 7);
        bw(12'h308, UPD | 77);
        br(A_ICNT, v); check("R10 foreign write ignored", v, 7);
        bw(12'h320, 3);
        br(A_CTRL, v); check("R10 foreign ctrl ignored", v, 0);
        br(12'h308, v); check("R10 foreign read zero", v, 0);
    endtask

    initial begin
        fork
            begin
                #(200000 * 20);
                miscompares++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        join_none
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_wstat();
        t_update();
        t_oneshot();
        t_interval();
        t_enable();
        t_halt();
        t_zero();
        t_decode();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule